// File: doc/BRIEF.md
# Single-Bit Conditional Branch Resolver

This block decides the outcome of a branch instruction whose condition is one bit picked out of a 64-bit register operand. A 6-bit position field chooses the bit, and a polarity flag chooses whether the branch goes when that bit is one or when it is zero. In the same pass the block forms the branch destination from the program counter and a signed 16-bit word offset. It also tells the pipeline that the next instruction is a delay slot.

A branch that arrives while it is itself in a delay slot (or a forbidden slot) is not resolved. The block refuses it and raises a reserved-instruction exception request. The decode logic is combinational. All results are captured in one output register stage, and a valid bit qualifies them. Redirecting fetch, flushing the pipeline and taking the exception vector are the job of the surrounding logic.

Top module: `bitbranch_resolver`

## Requirements
- R1: With `in_pol` = 1, a legal branch is taken exactly when bit `in_pos` of `in_operand` is 1 (bit 0 is the least significant bit).
- R2: With `in_pol` = 0, a legal branch is taken exactly when bit `in_pos` of `in_operand` is 0.
- R3: For a legal branch, `out_target` equals `in_pc` + 4 + (sign-extended `in_offset`) × 4, computed modulo 2^64.
- R4: When `in_in_slot` = 1 with a valid input, the next cycle shows `out_ri_exc` = 1, `out_taken` = 0 and `out_slot_next` = 0, and `out_target` keeps its previous value.
- R5: A legal branch sets `out_slot_next` = 1 and `out_ri_exc` = 0, whether or not the branch is taken.
- R6: `out_valid` is `in_valid` delayed by exactly one clock.
- R7: Synchronous active-high `rst` clears `out_valid`, `out_taken`, `out_slot_next`, `out_ri_exc` and `out_target` (to 0) on the next clock edge.
- R8: `out_taken` and `out_ri_exc` are never 1 in the same cycle.
- R9: A cycle with `in_valid` = 0 gives `out_taken`, `out_slot_next` and `out_ri_exc` all 0 on the next cycle. All other inputs are ignored in that cycle, and `out_target` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a branch this cycle |
| in_operand | input | 64 | Register value whose bit is tested |
| in_pos | input | 6 | Index of the tested bit |
| in_pol | input | 1 | 1: branch on bit one; 0: branch on bit zero |
| in_offset | input | 16 | Signed offset in instruction words |
| in_pc | input | 64 | Address of the branch instruction |
| in_in_slot | input | 1 | Branch sits in a delay or forbidden slot |
| out_valid | output | 1 | Registered results are valid |
| out_taken | output | 1 | Branch condition met |
| out_target | output | 64 | Branch destination address |
| out_slot_next | output | 1 | Following instruction is a delay slot |
| out_ri_exc | output | 1 | Reserved-instruction exception request |

## Verification
The assertions check the cycle-level rules on every clock: the one-cycle valid delay, that taken and exception never occur together, that a slotted branch gives only the exception, that a legal branch always marks the delay slot, that idle cycles leave the target unchanged, and that the bit test follows the operand's bit under both polarities. Only the bench's scenarios show that the destination arithmetic is right. They cover offset extremes, both signs and address wrap past 2^64. The bench also sweeps every bit position under both polarities with one-hot, inverted and dense operands, so a stuck or misrouted mask line shows up.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  // Classification of the incoming request, decided before the register stage.
  typedef enum logic [1:0] {
    RES_IDLE    = 2'd0,
    RES_BRANCH  = 2'd1,
    RES_REFUSED = 2'd2
  } res_kind_e;

endpackage

// File: rtl/bbr_cond.sv
module bbr_cond #(
  parameter int DATA_W = 64,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [POS_W-1:0]  pos,
  input  logic              pol,
  output logic [DATA_W-1:0] mask,
  output logic              hit
);

  // Polarity-adjusted view of the operand: a one in the view means "go".
  function automatic logic [DATA_W-1:0] polar_view(input logic [DATA_W-1:0] v,
                                                   input logic p);
    return p ? v : ~v;
  endfunction

  logic [DATA_W-1:0] view;

  // One decoder line per bit position.
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    assign mask[gi] = (pos == POS_W'(gi));
  end

  assign view = polar_view(operand, pol);
  assign hit  = |(mask & view);

endmodule

// File: rtl/bbr_target.sv
module bbr_target #(
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] target
);

  localparam int SHIFT  = $clog2(INSN_BYTES);
  localparam int EXT_W  = ADDR_W - OFF_W - SHIFT;

  // Word offset turned into a byte displacement of full address width.
  function automatic logic [ADDR_W-1:0] byte_disp(input logic [OFF_W-1:0] w);
    return {{EXT_W{w[OFF_W-1]}}, w, {SHIFT{1'b0}}};
  endfunction

  // Address of the instruction after the branch; wraps modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] fall_through(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(INSN_BYTES);
  endfunction

  assign target = fall_through(pc) + byte_disp(offset);

endmodule

// File: rtl/bbr_outreg.sv
module bbr_outreg
  import bbr_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  res_kind_e         kind,
  input  logic              hit,
  input  logic [ADDR_W-1:0] target_nxt,
  output logic              q_valid,
  output logic              q_taken,
  output logic              q_slot_next,
  output logic              q_exc,
  output logic [ADDR_W-1:0] q_target
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid     <= 1'b0;
      q_taken     <= 1'b0;
      q_slot_next <= 1'b0;
      q_exc       <= 1'b0;
      q_target    <= '0;
    end else begin
      q_valid <= (kind != RES_IDLE);
      unique case (kind)
        RES_BRANCH: begin
          q_taken     <= hit;
          q_slot_next <= 1'b1;
          q_exc       <= 1'b0;
          q_target    <= target_nxt;
        end
        RES_REFUSED: begin
          q_taken     <= 1'b0;
          q_slot_next <= 1'b0;
          q_exc       <= 1'b1;
        end
        default: begin
          q_taken     <= 1'b0;
          q_slot_next <= 1'b0;
          q_exc       <= 1'b0;
        end
      endcase
    end
  end

  // R8: taken and exception are mutually exclusive
  a_r8_taken_exc_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(q_taken && q_exc));

  // R4: a refused branch produces only the exception, target held
  a_r4_refused_only_exc: assert property (@(posedge clk) disable iff (rst)
    (kind == RES_REFUSED) |=> (q_exc && !q_taken && !q_slot_next && $stable(q_target)));

  // R9: idle cycle leaves the target and clears qualifiers
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (kind == RES_IDLE) |=> ($stable(q_target) && !q_taken && !q_exc && !q_slot_next));

endmodule

// File: rtl/bitbranch_resolver.sv
module bitbranch_resolver
  import bbr_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int POS_W      = $clog2(DATA_W),
  parameter int OFF_W      = 16,
  parameter int ADDR_W     = 64,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [POS_W-1:0]  in_pos,
  input  logic              in_pol,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_in_slot,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_slot_next,
  output logic              out_ri_exc
);

  // Named internal events
  res_kind_e         kind;
  logic [DATA_W-1:0] test_mask;
  logic              cond_hit;
  logic [ADDR_W-1:0] target_nxt;

  function automatic res_kind_e classify(input logic v, input logic slotted);
    if (!v)      return RES_IDLE;
    if (slotted) return RES_REFUSED;
    return RES_BRANCH;
  endfunction

  assign kind = classify(in_valid, in_in_slot);

  bbr_cond #(
    .DATA_W (DATA_W),
    .POS_W  (POS_W)
  ) u_cond (
    .operand (in_operand),
    .pos     (in_pos),
    .pol     (in_pol),
    .mask    (test_mask),
    .hit     (cond_hit)
  );

  bbr_target #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_target (
    .pc     (in_pc),
    .offset (in_offset),
    .target (target_nxt)
  );

  bbr_outreg #(
    .ADDR_W (ADDR_W)
  ) u_outreg (
    .clk         (clk),
    .rst         (rst),
    .kind        (kind),
    .hit         (cond_hit),
    .target_nxt  (target_nxt),
    .q_valid     (out_valid),
    .q_taken     (out_taken),
    .q_slot_next (out_slot_next),
    .q_exc       (out_ri_exc),
    .q_target    (out_target)
  );

  // R1 / R2: exactly one decoder line is active for the selected bit
  a_r1_mask_single: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(test_mask) == 1));

  // R1: set-polarity branch goes when the selected bit is one
  a_r1_pol_set: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_in_slot && in_pol) |=> (out_taken == $past(in_operand[in_pos])));

  // R2: clear-polarity branch goes when the selected bit is zero
  a_r2_pol_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_in_slot && !in_pol) |=> (out_taken == !$past(in_operand[in_pos])));

  // R5: a legal branch always marks the delay slot
  a_r5_slot_marked: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_in_slot) |=> (out_slot_next && !out_ri_exc));

  // R6: valid is delayed by one clock
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R7: reset clears the status outputs
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_taken && !out_ri_exc && !out_slot_next));

endmodule

// File: tb/bitbranch_resolver_bench.sv
module bitbranch_resolver_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic [5:0]  in_pos = '0;
  logic        in_pol = 1'b0;
  logic [15:0] in_offset = '0;
  logic [63:0] in_pc = '0;
  logic        in_in_slot = 1'b0;
  logic        out_valid, out_taken, out_slot_next, out_ri_exc;
  logic [63:0] out_target;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  bitbranch_resolver u_bitbranch_resolver (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_operand (in_operand),
    .in_pos (in_pos), .in_pol (in_pol), .in_offset (in_offset), .in_pc (in_pc),
    .in_in_slot (in_in_slot), .out_valid (out_valid), .out_taken (out_taken),
    .out_target (out_target), .out_slot_next (out_slot_next), .out_ri_exc (out_ri_exc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_target(input logic [63:0] pc, input logic [15:0] off);
    longint disp;
    disp = longint'($signed(off)) * 4;
    return pc + 64'd4 + 64'(disp);
  endfunction

  // Drive one request at a falling edge; results are checked one falling edge later.
  task automatic drive(input logic v, input logic [63:0] op, input logic [5:0] p,
                       input logic pl, input logic [15:0] off, input logic [63:0] pc,
                       input logic slot);
    @(negedge clk);
    in_valid = v; in_operand = op; in_pos = p; in_pol = pl;
    in_offset = off; in_pc = pc; in_in_slot = slot;
    @(negedge clk);
  endtask

  task automatic legal(input logic [63:0] op, input logic [5:0] p, input logic pl,
                       input logic [15:0] off, input logic [63:0] pc);
    logic exp_taken;
    exp_taken = pl ? op[p] : ~op[p];
    drive(1'b1, op, p, pl, off, pc, 1'b0);
    chk(pl ? "R1 taken" : "R2 taken", 64'(out_taken), 64'(exp_taken));
    chk("R5 slot mark", {62'd0, out_slot_next, out_ri_exc}, 64'd2);
    chk("R6 valid", 64'(out_valid), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic [63:0] dense;
    logic [15:0] offs [6];
    logic [63:0] pcs  [4];

    // R7: reset state
    @(negedge clk); @(negedge clk);
    chk("R7 reset flags", {60'd0, out_valid, out_taken, out_slot_next, out_ri_exc}, 64'd0);
    chk("R7 reset target", out_target, 64'd0);
    rst = 1'b0;

    // R1 / R2 / R5: every position, both polarities, several operand shapes
    dense = 64'hA5C3_0F96_7E21_D84B;
    for (int p = 0; p < 64; p++) begin
      for (int pl = 0; pl < 2; pl++) begin
        legal(64'd1 << p,    6'(p), 1'(pl), 16'd0, 64'h1000);
        legal(~(64'd1 << p), 6'(p), 1'(pl), 16'd0, 64'h1000);
        legal(dense,         6'(p), 1'(pl), 16'd0, 64'h1000);
        legal(~dense,        6'(p), 1'(pl), 16'd0, 64'h1000);
      end
    end

    // R3: offset extremes and wrap-around
    offs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};
    pcs  = '{64'h0, 64'h0000_0000_0040_0000, 64'hFFFF_FFFF_FFFF_FFFC, 64'h8000_0000_0000_0010};
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 4; j++) begin
        drive(1'b1, 64'd0, 6'd0, 1'b1, offs[i], pcs[j], 1'b0);
        chk("R3 target", out_target, ref_target(pcs[j], offs[i]));
      end
    end

    // R4 / R8: refused in a delay slot, target kept, even with a satisfied condition
    drive(1'b1, 64'd0, 6'd3, 1'b0, 16'h0010, 64'h2000, 1'b0);
    held = out_target;
    chk("R3 target before refuse", held, ref_target(64'h2000, 16'h0010));
    drive(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd7, 1'b1, 16'h0100, 64'h9000, 1'b1);
    chk("R4 exc flags", {61'd0, out_ri_exc, out_taken, out_slot_next}, 64'd4);
    chk("R4 target held", out_target, held);
    chk("R8 exclusive", 64'(out_taken & out_ri_exc), 64'd0);
    chk("R6 valid on refuse", 64'(out_valid), 64'd1);
    drive(1'b1, 64'd0, 6'd7, 1'b0, 16'h0100, 64'h9000, 1'b1);
    chk("R4 exc flags clear pol", {61'd0, out_ri_exc, out_taken, out_slot_next}, 64'd4);

    // R9: idle cycle with busy inputs
    drive(1'b1, 64'd1, 6'd0, 1'b1, 16'h0002, 64'h3000, 1'b0);
    held = out_target;
    drive(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd5, 1'b1, 16'h7777, 64'h5555, 1'b1);
    chk("R9 idle flags", {60'd0, out_valid, out_taken, out_slot_next, out_ri_exc}, 64'd0);
    chk("R9 idle target", out_target, held);

    // R6 / R5: back-to-back legal requests then drop
    legal(64'h0, 6'd63, 1'b0, 16'hFFFE, 64'h4000);
    chk("R3 back-to-back", out_target, ref_target(64'h4000, 16'hFFFE));
    drive(1'b0, 64'd0, 6'd0, 1'b0, 16'd0, 64'd0, 1'b0);
    chk("R6 valid drop", 64'(out_valid), 64'd0);

    // R7: reset in the middle of activity
    drive(1'b1, 64'd0, 6'd0, 1'b0, 16'h0001, 64'h100, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R7 mid reset", {59'd0, out_valid, out_taken, out_slot_next, out_ri_exc, 1'b0}, 64'd0);
    chk("R7 mid reset target", out_target, 64'd0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule